// File: doc/BRIEF.md
# Triple-Buffer Frame Manager

This block decides which of three frame buffers the display scans out and which one the renderer draws into. It holds only buffer indices (0, 1 and 2). The pixel memory, the renderer and the display timing all sit outside it. One index is always the front buffer seen by the display. The other two belong to the renderer side, either as the buffer being drawn or as finished frames waiting to be shown. The renderer draws into `draw_idx` while `draw_valid` is high and pulses `frame_done` when that frame is finished. The display timing pulses `refresh` at each refresh boundary, and at that point the front index may change.

`queue_mode` selects the policy. When it is low (newest-frame policy), at most one finished frame waits for display. A newer completion replaces it, the replaced buffer goes straight back to the renderer, and `drop_count` counts the discarded frames, so the renderer never waits. When it is high (queue policy), the block acts as a three-long first-in first-out chain. Up to two finished frames wait, every one of them is shown in completion order, and the renderer stalls while both back buffers hold finished frames.

Top module: `tbm_triple_buffer`

## Requirements
- R1: After reset, front_idx = 0, front_valid = 0, draw_idx = 1, draw_valid = 1 and drop_count = 0.
- R2: front_idx and the indices of the waiting and drawn buffers are always three distinct values in 0..2. While draw_valid = 1, draw_idx differs from front_idx.
- R3: A frame_done pulse while draw_valid = 0 is ignored and changes no output.
- R4: On refresh with at least one finished frame waiting, the next cycle's front_idx is the oldest waiting frame and front_valid becomes 1. The old front buffer returns to the renderer side.
- R5: On refresh with no finished frame waiting, front_idx stays the same, so the frame is repeated.
- R6: Newest-frame policy (queue_mode = 0): frame_done marks the drawn buffer as the single waiting frame. If a frame was already waiting, it is discarded and its buffer becomes the next draw_idx. draw_valid stays 1.
- R7: Queue policy (queue_mode = 1): finished frames queue up to two deep and are shown in completion order. After the second one, draw_valid = 0 and draw_idx = 3 until a refresh frees the old front buffer, which then becomes draw_idx.
- R8: When an accepted frame_done and a refresh fall in the same cycle, the completion is applied first. With nothing else waiting (or in newest-frame policy), the just-finished buffer becomes the front buffer.
- R9: drop_count adds 1 for each frame discarded under R6, never changes under the queue policy, and wraps modulo 2^DROP_W (DROP_W = 8 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| queue_mode | input | 1 | 0 = newest-frame policy, 1 = in-order queue policy |
| frame_done | input | 1 | One-cycle pulse: the renderer finished the frame in draw_idx |
| refresh | input | 1 | One-cycle pulse at a display refresh boundary |
| draw_idx | output | 2 | Buffer the renderer draws into (3 while stalled) |
| draw_valid | output | 1 | Renderer may draw; low while the queue is full |
| front_idx | output | 2 | Buffer scanned out by the display |
| front_valid | output | 1 | At least one finished frame has been presented |
| drop_count | output | DROP_W | Count of discarded unshown frames |

## Verification
A corrupted index set shows at the ports as soon as draw_idx equals front_idx. That would be a torn frame, and it appears in the same cycle as the bad state. A wrong order of waiting frames, or a lost finished frame, shows as a wrong front_idx on the first refresh after the error. A stall that is wrongly raised or wrongly cleared shows as draw_valid in the cycle after the completion or refresh that caused it. The bench compares all outputs every cycle against its own list-based model, so any divergence is reported within one clock of the event that caused it.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

  localparam int NUM_BUF = 3;
  localparam int IDX_W   = 2;
  localparam logic [IDX_W-1:0] NO_IDX = 2'd3;

  // Index ring state. slot_a/slot_b hold the two non-front buffers in age
  // order; the first 'waiting' of them are finished frames, the next is drawn.
  typedef struct packed {
    logic [IDX_W-1:0] front;
    logic [IDX_W-1:0] slot_a;
    logic [IDX_W-1:0] slot_b;
    logic [1:0]       waiting;
    logic             shown;
  } tbm_state_t;

  localparam tbm_state_t RESET_STATE = '{front: 2'd0, slot_a: 2'd1, slot_b: 2'd2,
                                         waiting: 2'd0, shown: 1'b0};

  function automatic logic [IDX_W-1:0] fn_draw_idx(input tbm_state_t s);
    case (s.waiting)
      2'd0:    return s.slot_a;
      2'd1:    return s.slot_b;
      default: return NO_IDX;
    endcase
  endfunction

  function automatic logic fn_can_draw(input tbm_state_t s);
    return s.waiting < 2'd2;
  endfunction

  function automatic logic fn_done_drops(input tbm_state_t s, input logic newest);
    return newest && (s.waiting == 2'd1);
  endfunction

  function automatic tbm_state_t fn_after_done(input tbm_state_t s, input logic newest);
    tbm_state_t r;
    r = s;
    if (fn_done_drops(s, newest)) begin
      r.slot_a = s.slot_b;
      r.slot_b = s.slot_a;
    end else if (fn_can_draw(s)) begin
      r.waiting = s.waiting + 2'd1;
    end
    return r;
  endfunction

  function automatic tbm_state_t fn_after_refresh(input tbm_state_t s);
    tbm_state_t r;
    r = s;
    if (s.waiting != 2'd0) begin
      r.front   = s.slot_a;
      r.slot_a  = s.slot_b;
      r.slot_b  = s.front;
      r.waiting = s.waiting - 2'd1;
      r.shown   = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tbm_done_stage.sv
module tbm_done_stage
  import tbm_pkg::*;
(
  input  tbm_state_t st_i,
  input  logic       done_i,
  input  logic       newest_i,
  output tbm_state_t st_o,
  output logic       accept_o,
  output logic       drop_o
);
  always_comb begin
    accept_o = done_i && fn_can_draw(st_i);
    drop_o   = accept_o && fn_done_drops(st_i, newest_i);
    st_o     = accept_o ? fn_after_done(st_i, newest_i) : st_i;
  end
endmodule

// File: rtl/tbm_refresh_stage.sv
module tbm_refresh_stage
  import tbm_pkg::*;
(
  input  tbm_state_t st_i,
  input  logic       refresh_i,
  output tbm_state_t st_o
);
  always_comb begin
    st_o = refresh_i ? fn_after_refresh(st_i) : st_i;
  end
endmodule

// File: rtl/tbm_drop_ctr.sv
module tbm_drop_ctr #(
  parameter int W        = 8,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  generate
    if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           count_o <= '0;
        else if (inc_i && (count_o != '1))    count_o <= count_o + ONE;
      end
    end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_o <= '0;
        else if (inc_i)  count_o <= count_o + ONE;
      end
    end
  endgenerate
endmodule

// File: rtl/tbm_triple_buffer.sv
module tbm_triple_buffer
  import tbm_pkg::*;
#(
  parameter int DROP_W   = 8,
  parameter bit DROP_SAT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queue_mode,
  input  logic              frame_done,
  input  logic              refresh,
  output logic [1:0]        draw_idx,
  output logic              draw_valid,
  output logic [1:0]        front_idx,
  output logic              front_valid,
  output logic [DROP_W-1:0] drop_count
);
  tbm_state_t st_q, st_mid, st_nxt;

  // Named internal events, used by the bound checker.
  logic       done_accept;
  logic       drop_event;
  logic [1:0] st_front, st_slot_a, st_slot_b, pend_cnt;

  // Completion is resolved before the refresh of the same cycle.
  tbm_done_stage u_done (
    .st_i     (st_q),
    .done_i   (frame_done),
    .newest_i (!queue_mode),
    .st_o     (st_mid),
    .accept_o (done_accept),
    .drop_o   (drop_event)
  );

  tbm_refresh_stage u_refresh (
    .st_i      (st_mid),
    .refresh_i (refresh),
    .st_o      (st_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RESET_STATE;
    else        st_q <= st_nxt;
  end

  tbm_drop_ctr #(.W(DROP_W), .SATURATE(DROP_SAT)) u_drops (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (drop_event),
    .count_o (drop_count)
  );

  assign draw_idx    = fn_draw_idx(st_q);
  assign draw_valid  = fn_can_draw(st_q);
  assign front_idx   = st_q.front;
  assign front_valid = st_q.shown;
  assign st_front    = st_q.front;
  assign st_slot_a   = st_q.slot_a;
  assign st_slot_b   = st_q.slot_b;
  assign pend_cnt    = st_q.waiting;
endmodule

// File: rtl/tbm_triple_buffer_chk.sv
module tbm_triple_buffer_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              queue_mode,
  input logic              frame_done,
  input logic              refresh,
  input logic [1:0]        draw_idx,
  input logic              draw_valid,
  input logic [1:0]        front_idx,
  input logic              front_valid,
  input logic [DROP_W-1:0] drop_count,
  input logic              done_accept,
  input logic [1:0]        st_front,
  input logic [1:0]        st_slot_a,
  input logic [1:0]        st_slot_b,
  input logic [1:0]        pend_cnt
);
  a_r2_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (st_front != st_slot_a) && (st_front != st_slot_b) && (st_slot_a != st_slot_b)
    && (st_front != 2'd3) && (st_slot_a != 2'd3) && (st_slot_b != 2'd3));

  a_r2_no_tear: assert property (@(posedge clk) disable iff (!rst_n)
    draw_valid |-> (draw_idx != front_idx));

  a_r3_stall_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !draw_valid && !refresh) |=> ($stable(draw_idx) && $stable(front_idx) && $stable(drop_count)));

  a_r4_present: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !done_accept && pend_cnt != 2'd0) |=> (front_idx == $past(st_slot_a)) && front_valid);

  a_r5_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !done_accept && pend_cnt == 2'd0) |=> $stable(front_idx));

  a_r6_never_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_mode && done_accept) |=> draw_valid);

  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (queue_mode && done_accept && pend_cnt == 2'd1 && !refresh) |=> !draw_valid);

  a_r8_done_first: assert property (@(posedge clk) disable iff (!rst_n)
    (done_accept && refresh && (pend_cnt == 2'd0 || !queue_mode)) |=> (front_idx == $past(draw_idx)));

  a_r9_queue_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    queue_mode |=> $stable(drop_count));
endmodule

bind tbm_triple_buffer tbm_triple_buffer_chk #(.DROP_W(DROP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .queue_mode  (queue_mode),
  .frame_done  (frame_done),
  .refresh     (refresh),
  .draw_idx    (draw_idx),
  .draw_valid  (draw_valid),
  .front_idx   (front_idx),
  .front_valid (front_valid),
  .drop_count  (drop_count),
  .done_accept (done_accept),
  .st_front    (st_front),
  .st_slot_a   (st_slot_a),
  .st_slot_b   (st_slot_b),
  .pend_cnt    (pend_cnt)
);

// File: tb/test_tbm_triple_buffer.sv
`timescale 1ns/1ps
module test_tbm_triple_buffer;
  localparam int DROP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic queue_mode = 1'b0, frame_done = 1'b0, refresh = 1'b0;
  logic [1:0] draw_idx, front_idx;
  logic draw_valid, front_valid;
  logic [DROP_W-1:0] drop_count;

  int vectors = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tbm_triple_buffer #(.DROP_W(DROP_W)) i_tbm_triple_buffer (
    .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode), .frame_done(frame_done),
    .refresh(refresh), .draw_idx(draw_idx), .draw_valid(draw_valid),
    .front_idx(front_idx), .front_valid(front_valid), .drop_count(drop_count));

  // Bench model: display index, list of finished frames (oldest first), drawn index.
  int m_front, m_draw, m_np, m_drop;
  int m_list[2];
  bit m_shown;
  string m_tag;

  function automatic int other_of(int a, int b);
    return 3 - a - b;
  endfunction

  task automatic model_reset();
    m_front = 0; m_draw = 1; m_np = 0; m_drop = 0; m_shown = 0;
    m_list[0] = 0; m_list[1] = 0;
  endtask

  task automatic model_step(bit qm, bit d, bit r);
    m_tag = "R2";
    if (d && m_draw == 3) m_tag = "R3";
    if (d && m_draw != 3) begin
      if (!qm && m_np == 1) begin
        int old;
        old = m_list[0];
        m_list[0] = m_draw;
        m_draw = old;
        m_drop = (m_drop + 1) % (1 << DROP_W);
        m_tag = "R6";
      end else begin
        m_list[m_np] = m_draw;
        m_np++;
        m_draw = (m_np == 2) ? 3 : other_of(m_front, m_list[0]);
        m_tag = qm ? "R7" : "R6";
      end
      if (r) m_tag = "R8";
    end
    if (r) begin
      if (m_np > 0) begin
        int old;
        old = m_front;
        m_front = m_list[0];
        m_list[0] = m_list[1];
        m_np--;
        m_shown = 1;
        if (m_draw == 3) m_draw = old;
        if (!d) m_tag = "R4";
      end else if (!d) begin
        m_tag = "R5";
      end
    end
  endtask

  task automatic check(string tag, int got, int exp, string what);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, int'(front_idx), m_front, "front_idx");
    check(tag, int'(front_valid), int'(m_shown), "front_valid");
    check(tag, int'(draw_idx), m_draw, "draw_idx");
    check(tag, int'(draw_valid), int'(m_draw != 3), "draw_valid");
    check(tag, int'(drop_count), m_drop, "drop_count");
    if (draw_valid) check("R2", int'(draw_idx != front_idx), 1, "draw differs from front");
  endtask

  task automatic cyc(bit qm, bit d, bit r);
    queue_mode = qm; frame_done = d; refresh = r;
    model_step(qm, d, r);
    @(negedge clk);
    compare_all(m_tag);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");
    @(negedge clk);
    compare_all("R1");

    // R5: refresh with nothing finished repeats front 0
    cyc(0, 0, 1);
    // R8: completion and refresh together, just-finished frame shown
    cyc(0, 1, 1);
    check("R8", int'(front_idx), 1, "front after same-cycle done");
    // R6: two completions with no refresh, second discards first
    cyc(0, 1, 0);
    cyc(0, 1, 0);
    check("R6", int'(drop_count), 1, "one drop");
    check("R6", int'(draw_valid), 1, "no stall");
    cyc(0, 0, 1);
    // R7: queue fill, stall, order of presentation
    cyc(1, 1, 0);
    cyc(1, 1, 0);
    check("R7", int'(draw_valid), 0, "queue full stall");
    check("R7", int'(draw_idx), 3, "stalled draw index");
    // R3: done while stalled ignored
    cyc(1, 1, 0);
    cyc(1, 0, 1);
    check("R7", int'(draw_valid), 1, "stall released");
    cyc(1, 0, 1);
    cyc(1, 0, 1);
    // R9: drop counter wrap in newest policy
    for (int i = 0; i < 258; i++) cyc(0, 1, 0);
    check("R9", int'(drop_count), m_drop, "drop wrap");
    cyc(0, 0, 1);
    // Constrained random mix of policies and events
    for (int i = 0; i < 4000; i++) begin
      bit qm, d, r;
      qm = ((i / 200) % 2) == 1;
      d  = ($urandom % 100) < 45;
      r  = ($urandom % 100) < 30;
      cyc(qm, d, r);
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule